// File: doc/BRIEF.md
# Two-Module Current-Source Rectifier Gate Pattern Generator

This block produces the gate commands for a cascaded rectifier front end built from two identical three-phase current-source bridges, an upper and a lower one, stacked in series. Each bridge has three switches that tie an input phase to the positive rail and three that tie a phase to the negative rail. A controller outside the block supplies the input-current sector (1 to 6) and a 16-bit duty fraction `dx`. The block runs a free-running sampling-period counter and builds one gate pattern per period.

In every valid sector one switch stays closed for the whole period. The two switches on the opposite rail share the period between them: the first conducts for the `dx` part and the second for the rest. No zero vector is used, so the DC link always sees a line-to-line voltage. The sector and the duty are captured only at period boundaries. A flag tells a downstream inverter sequencer which sub-interval is active. An illegal sector code opens every switch for the period and raises a fault flag.

Top module: `rect_sector_gate`

## Requirements
- R1: After reset, and until the end of the first full sampling period of `PERIOD_CYC = CLK_HZ/SAMPLE_HZ` cycles, every gate output is 0 and `dy_phase` and `sector_fault` are 0.
- R2: `gate_upper` and `gate_lower` are equal in every cycle.
- R3: The gate bit order is [0] a+, [1] b+, [2] c+, [3] a-, [4] b-, [5] c-. Each sector gives a held switch, a first modulated switch and a second modulated switch: 1 holds a+ (b-, c-); 2 holds c- (b+, a+); 3 holds b+ (c-, a-); 4 holds a- (c+, b+); 5 holds c+ (a-, b-); 6 holds b- (c+, a+).
- R4: With a valid latched sector, the first modulated switch is on during period counts 0 to K-1 and the second during counts K to PERIOD_CYC-1, where K = floor(dx·PERIOD_CYC/65536). The held switch is on for all counts.
- R5: `dy_phase` is 1 exactly while the second modulated switch is the one selected, and it stays 1 until the period ends.
- R6: `sector` and `dx` are sampled only on the last count of a period. A change at any other time has no effect on the outputs until the next period.
- R7: In a valid sector exactly one positive-rail switch and exactly one negative-rail switch are on in every cycle.
- R8: A latched sector code of 0 or 7 forces all gates to 0 and `dy_phase` to 0, and holds `sector_fault` at 1 for the whole period.
- R9: With `dx` = 0, the second modulated switch conducts for the entire period. With `dx` = 65535, the second switch still gets at least one count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sector | input | 3 | Input-current sector, 1 to 6 legal |
| dx | input | 16 | First-switch share of the period, fraction of 65536 |
| gate_upper | output | 6 | Gate commands, upper bridge |
| gate_lower | output | 6 | Gate commands, lower bridge |
| dy_phase | output | 1 | High during the second modulated sub-interval |
| sector_fault | output | 1 | Latched sector code illegal this period |

## Verification
The bench goes after the duty extremes, where K is 0 or PERIOD_CYC-1. A design with an off-by-one split would drop the first switch for one count or leave the period with no second sub-interval. It changes the inputs in the middle of a period, so a design that does not capture them at the boundary shows glitching gates or a fault mid-period. It drives illegal codes 0 and 7, which a partial decode would turn into a live pattern. It also steps through all six sectors, so a swapped pair in the table appears as two same-rail switches or a wrong held switch.

// File: rtl/rsg_pkg.sv
package rsg_pkg;
   typedef logic [5:0] sw_t;
   localparam int SW_AP = 0;
   localparam int SW_BP = 1;
   localparam int SW_CP = 2;
   localparam int SW_AN = 3;
   localparam int SW_BN = 4;
   localparam int SW_CN = 5;

   function automatic sw_t one_sw(input int idx);
      sw_t v;
      v = '0;
      v[idx] = 1'b1;
      return v;
   endfunction
endpackage

// File: rtl/rsg_period_timer.sv
module rsg_period_timer #(
   parameter int PERIOD_CYC = 1250,
   parameter int CW = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic [CW-1:0] cnt,
   output logic          last
);
   localparam logic [CW-1:0] LAST_V = CW'(PERIOD_CYC - 1);

   assign last = (cnt == LAST_V);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (last) cnt <= '0;
      else           cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/rsg_duty_latch.sv
module rsg_duty_latch #(
   parameter int PERIOD_CYC = 1250,
   parameter int CW = 11,
   parameter int DX_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [2:0]      sector_in,
   input  logic [DX_W-1:0] dx_in,
   output logic [2:0]      sector_q,
   output logic [CW-1:0]   first_len_q,
   output logic            armed_q
);
   localparam int PW = DX_W + CW;
   localparam logic [PW-1:0] PERIOD_V = PW'(PERIOD_CYC);

   logic [PW-1:0] prod;
   assign prod = PW'(dx_in) * PERIOD_V;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sector_q    <= '0;
         first_len_q <= '0;
         armed_q     <= 1'b0;
      end else if (load) begin
         sector_q    <= sector_in;
         first_len_q <= prod[PW-1:DX_W];
         armed_q     <= 1'b1;
      end
   end
endmodule

// File: rtl/rsg_sector_map.sv
module rsg_sector_map
   import rsg_pkg::*;
(
   input  logic [2:0] sector,
   output logic       ok,
   output sw_t        hold_sw,
   output sw_t        first_sw,
   output sw_t        second_sw
);
   always_comb begin
      ok        = 1'b1;
      hold_sw   = '0;
      first_sw  = '0;
      second_sw = '0;
      unique case (sector)
         3'd1: begin hold_sw = one_sw(SW_AP); first_sw = one_sw(SW_BN); second_sw = one_sw(SW_CN); end
         3'd2: begin hold_sw = one_sw(SW_CN); first_sw = one_sw(SW_BP); second_sw = one_sw(SW_AP); end
         3'd3: begin hold_sw = one_sw(SW_BP); first_sw = one_sw(SW_CN); second_sw = one_sw(SW_AN); end
         3'd4: begin hold_sw = one_sw(SW_AN); first_sw = one_sw(SW_CP); second_sw = one_sw(SW_BP); end
         3'd5: begin hold_sw = one_sw(SW_CP); first_sw = one_sw(SW_AN); second_sw = one_sw(SW_BN); end
         3'd6: begin hold_sw = one_sw(SW_BN); first_sw = one_sw(SW_CP); second_sw = one_sw(SW_AP); end
         default: ok = 1'b0;
      endcase
   end
endmodule

// File: rtl/rect_sector_gate.sv
module rect_sector_gate
   import rsg_pkg::*;
#(
   parameter int CLK_HZ    = 125_000_000,
   parameter int SAMPLE_HZ = 100_000,
   parameter int DX_W      = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [2:0]      sector,
   input  logic [DX_W-1:0] dx,
   output logic [5:0]      gate_upper,
   output logic [5:0]      gate_lower,
   output logic            dy_phase,
   output logic            sector_fault
);
   localparam int PERIOD_CYC = CLK_HZ / SAMPLE_HZ;
   localparam int CNT_W      = $clog2(PERIOD_CYC);
   localparam int N_BRIDGE   = 2;

   generate
      if (PERIOD_CYC < 2) begin : g_bad_period
         $error("rect_sector_gate: period must span at least two clocks");
      end
      if (DX_W < 2) begin : g_bad_dx
         $error("rect_sector_gate: duty width too small");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;
   logic             last;
   logic [2:0]       sec_q;
   logic [CNT_W-1:0] first_len;
   logic             armed;
   logic             map_ok;
   sw_t              hold_sw, first_sw, second_sw;
   sw_t              gate_w;
   logic             active, in_second;

   rsg_period_timer #(.PERIOD_CYC(PERIOD_CYC), .CW(CNT_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .cnt(cnt), .last(last)
   );

   rsg_duty_latch #(.PERIOD_CYC(PERIOD_CYC), .CW(CNT_W), .DX_W(DX_W)) u_lat (
      .clk(clk), .rst_n(rst_n), .load(last), .sector_in(sector), .dx_in(dx),
      .sector_q(sec_q), .first_len_q(first_len), .armed_q(armed)
   );

   rsg_sector_map u_map (
      .sector(sec_q), .ok(map_ok), .hold_sw(hold_sw),
      .first_sw(first_sw), .second_sw(second_sw)
   );

   assign active       = armed & map_ok;
   assign sector_fault = armed & ~map_ok;
   assign in_second    = (cnt >= first_len);
   assign dy_phase     = active & in_second;

   generate
      for (genvar i = 0; i < 6; i++) begin : g_sw
         assign gate_w[i] = active & (hold_sw[i] | (in_second ? second_sw[i] : first_sw[i]));
      end
      for (genvar m = 0; m < N_BRIDGE; m++) begin : g_bridge
         if (m == 0) begin : g_up
            assign gate_upper = gate_w;
         end else begin : g_lo
            assign gate_lower = gate_w;
         end
      end
   endgenerate
endmodule

// File: rtl/rsg_gate_chk.sv
module rsg_gate_chk #(
   parameter int CW = 11,
   parameter int PERIOD_CYC = 1250
) (
   input logic          clk,
   input logic          rst_n,
   input logic [5:0]    up,
   input logic [5:0]    lo,
   input logic          dy_phase,
   input logic          fault,
   input logic [CW-1:0] cnt
);
   localparam logic [CW-1:0] LAST_V = CW'(PERIOD_CYC - 1);

   // R2
   pair_match_chk: assert property (@(posedge clk) disable iff (!rst_n) up == lo);

   // R7
   one_pos_one_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|up) |-> ($countones(up[2:0]) == 1 && $countones(up[5:3]) == 1));

   // R8
   fault_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> (up == 6'd0 && !dy_phase));

   // R5
   phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dy_phase && cnt != LAST_V) |=> dy_phase);

   // R6
   fault_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != '0) |-> $stable(fault));
endmodule

bind rect_sector_gate rsg_gate_chk #(.CW(CNT_W), .PERIOD_CYC(PERIOD_CYC)) u_chk (
   .clk(clk), .rst_n(rst_n), .up(gate_upper), .lo(gate_lower),
   .dy_phase(dy_phase), .fault(sector_fault), .cnt(cnt)
);

// File: tb/sim_rect_sector_gate.sv
module sim_rect_sector_gate;
   localparam int P = 50;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  sector = 3'd0;
   logic [15:0] dx = 16'd0;
   logic [5:0]  gate_upper, gate_lower;
   logic        dy_phase, sector_fault;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #4 clk = ~clk;

   rect_sector_gate #(.CLK_HZ(5_000_000), .SAMPLE_HZ(100_000), .DX_W(16)) u0 (
      .clk(clk), .rst_n(rst_n), .sector(sector), .dx(dx),
      .gate_upper(gate_upper), .gate_lower(gate_lower),
      .dy_phase(dy_phase), .sector_fault(sector_fault)
   );

   // reference state
   int          m_cnt;
   bit          m_valid;
   logic [2:0]  m_sec;
   int          m_k;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt <= 0; m_valid <= 0; m_sec <= 3'd0; m_k <= 0;
      end else begin
         m_cnt <= (m_cnt == P-1) ? 0 : m_cnt + 1;
         if (m_cnt == P-1) begin
            m_valid <= 1;
            m_sec   <= sector;
            m_k     <= int'((longint'(dx) * P) >> 16);
         end
      end
   end

   function automatic logic [17:0] sec_tab(input logic [2:0] s);
      // {hold, first, second} one-hot, bit order a+ b+ c+ a- b- c-
      case (s)
         3'd1: return {6'b000001, 6'b010000, 6'b100000};
         3'd2: return {6'b100000, 6'b000010, 6'b000001};
         3'd3: return {6'b000010, 6'b100000, 6'b001000};
         3'd4: return {6'b001000, 6'b000100, 6'b000010};
         3'd5: return {6'b000100, 6'b001000, 6'b010000};
         3'd6: return {6'b010000, 6'b000100, 6'b000001};
         default: return 18'd0;
      endcase
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s t=%0t actual=%0h expected=%0h", tag, $time, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic [17:0] t;
         logic [5:0]  eg;
         bit          ok, sec2;
         string       tag;
         t    = sec_tab(m_sec);
         ok   = m_valid && (m_sec >= 3'd1 && m_sec <= 3'd6);
         sec2 = (m_cnt >= m_k);
         eg   = ok ? (t[17:12] | (sec2 ? t[5:0] : t[11:6])) : 6'd0;
         if (!m_valid)            tag = "R1";
         else if (!ok)            tag = "R8";
         else if (m_k == 0)       tag = "R9";
         else if (sector != m_sec) tag = "R6";
         else                     tag = "R3/R4";
         check(tag, gate_upper, eg);
         check("R2", gate_lower, gate_upper);
         check("R5", dy_phase, ok && sec2);
         check(m_valid ? "R8" : "R1", sector_fault, m_valid && !ok);
         if (ok) check("R7", {$countones(gate_upper[2:0]), $countones(gate_upper[5:3])}, 2'b11 == 2'b11 ? 64'h0000000100000001 : 0);
      end
   end

   task automatic hold_periods(input logic [2:0] s, input logic [15:0] d, input int np);
      @(negedge clk);
      sector = s; dx = d;
      repeat (np * P) @(negedge clk);
   endtask

   initial begin
      void'($urandom(32'd1789));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: first period idle regardless of inputs
      sector = 3'd3; dx = 16'h8000;
      repeat (P - 5) @(negedge clk);
      // directed corner cases
      hold_periods(3'd1, 16'd0, 2);       // R9 full second switch
      hold_periods(3'd6, 16'hFFFF, 2);    // R9 max duty
      hold_periods(3'd0, 16'h4000, 2);    // R8
      hold_periods(3'd7, 16'h4000, 2);    // R8
      hold_periods(3'd2, 16'h8000, 2);
      // R6: mid-period change to an illegal code
      hold_periods(3'd4, 16'h3000, 1);
      repeat (P/2) @(negedge clk);
      sector = 3'd0; dx = 16'hF000;
      repeat (P/3) @(negedge clk);
      sector = 3'd5; dx = 16'h1000;
      repeat (2 * P) @(negedge clk);
      for (int s = 1; s <= 6; s++) hold_periods(3'(s), 16'h5555, 1);
      // random mix with mid-period jitter
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         if (($urandom % 16) == 0) begin
            sector = 3'(($urandom % 10 < 8) ? ($urandom % 6) + 1 : (($urandom % 2) ? 7 : 0));
            dx     = 16'($urandom);
         end
      end
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule